// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Control Front End

This block is the control side of a pipelined synchronous SRAM whose data bus is shared between reads and writes. It captures the address, chip selects, address strobes, advance and write controls on every rising clock edge. It decodes them into an access for the current cycle: start, continue, suspend, deselect or no operation. It turns the global write and the per-byte write controls into a mask over four byte lanes, and applies that access to a built-in behavioural storage array. Read data leaves through a two-register pipeline. The drive enable of the shared bus is formed from the asynchronous output enable, the read pipeline and a write-hold flag.

An access starts when a strobe is sampled. Two strobes exist: a processor strobe that only counts while the primary chip select is active, and a controller strobe that always counts. A started access stays open, and later cycles either move on to the next burst address, which an external sequencer supplies on `seq_addr_i`, or repeat the current address. A sleep input closes any open access and blocks all traffic. A short recovery window follows sleep, during which write attempts are dropped.

Top module: `ssram_ctl_front`

## Requirements
- R1: Every synchronous input is acted on only as sampled at a rising clock edge; a strobe pulse that begins and ends between two edges causes no access.
- R2: When the global write (`gw_n_i` low) is sampled during an access, all four byte lanes of the addressed word are written, whatever `bwe_n_i` and `bw_n_i` hold.
- R3: When the global write is inactive and `bwe_n_i` is low, lane i (bits 8i+7 down to 8i) is written exactly when bit i of `bw_n_i` is low. With `bwe_n_i` high, or with all four bits of `bw_n_i` high, the access is a read.
- R4: In any cycle whose sampled access is a write, `dq_oe_o` is low whatever `oe_n_i` holds.
- R5: `oe_n_i` acts without a clock: while it is high, `dq_oe_o` is low and `dq_o` is zero within the same cycle.
- R6: After a write, the bus stays undriven through reads that continue or suspend the access; it is driven again only for reads begun by a strobe.
- R7: A read sampled at edge k drives its word on `dq_o`, with `dq_oe_o` high, after edge k+2. With `adv_n_i` low and no strobe, each further cycle reads the word at `seq_addr_i`, giving one new word per cycle.
- R8: A controller strobe sampled while the chip is not selected (select means `ce_n_i` low, `ce2_i` high and `ce3_n_i` low) closes the access. A processor strobe sampled while `ce_n_i` is high is ignored, and an open access goes on as if no strobe were present.
- R9: After a deselect is sampled at edge k, `dq_oe_o` is low from edge k+1 on, and reads still in the pipeline are dropped.
- R10: While `sleep_i` is sampled high, no access takes place, the open access is closed, and `dq_oe_o` is low from the next edge on. After sleep ends, the bus stays undriven until a new read has been started.
- R11: In the two cycles after `sleep_i` is first sampled low, a write attempt is dropped and leaves the array unchanged. Reads and deselects are accepted in those cycles.
- R12: An open access sampled with neither strobe and with `adv_n_i` high repeats its current address.
- R13: After reset, the bus is undriven and no access is open until a strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge samples every synchronous input |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address taken when a strobe starts an access |
| seq_addr_i | input | AW | Next burst address from the external sequencer |
| ce_n_i | input | 1 | Primary chip select, active low; also qualifies the processor strobe |
| ce2_i | input | 1 | Expansion chip select, active high |
| ce3_n_i | input | 1 | Expansion chip select, active low |
| adsp_n_i | input | 1 | Processor address strobe, active low |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Advance to `seq_addr_i`, active low |
| gw_n_i | input | 1 | Global write of all lanes, active low |
| bwe_n_i | input | 1 | Byte write enable, active low |
| bw_n_i | input | NB | Per-lane byte selects, active low |
| wdata_i | input | NB*BW | Write data, sampled with the write controls |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| dq_o | output | NB*BW | Read data; zero while not driven |
| dq_oe_o | output | 1 | Drive enable for the shared data bus |

## Verification
On every cycle, the bound assertions check the bus gating rules: the output enable, write cycles, the cycle after a write, the cycle after a deselect or sleep, and the recovery window after sleep. They also check that the lane mask reaching the array matches the sampled global or byte write controls. Only the bench's scenarios can show that the correct word comes out two edges after its read, and that bursts step through sequencer addresses or hold on a suspend. The same holds for showing that bytes left unselected keep their old value, that a strobe-begun read reopens the bus after a write, that an ignored processor strobe leaves a burst running, and that writes dropped during recovery never reach the array.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

   // Operation decoded for the current cycle from the sampled controls
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_DESEL = 2'd3
   } op_e;

endpackage

// File: rtl/ssram_in_reg.sv
module ssram_in_reg #(
   parameter int AW = 6,
   parameter int NB = 4,
   parameter int BW = 8,
   localparam int DW = NB * BW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] seq_addr_i,
   input  logic          ce_n_i,
   input  logic          ce2_i,
   input  logic          ce3_n_i,
   input  logic          adsp_n_i,
   input  logic          adsc_n_i,
   input  logic          adv_n_i,
   input  logic          gw_n_i,
   input  logic          bwe_n_i,
   input  logic [NB-1:0] bw_n_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          sleep_i,
   output logic [AW-1:0] addr_q,
   output logic [AW-1:0] seq_q,
   output logic          ce_n_q,
   output logic          ce2_q,
   output logic          ce3_n_q,
   output logic          adsp_n_q,
   output logic          adsc_n_q,
   output logic          adv_n_q,
   output logic          gw_n_q,
   output logic          bwe_n_q,
   output logic [NB-1:0] bw_n_q,
   output logic [DW-1:0] wdata_q,
   output logic          sleep_q
);

   // Controls reset to their inactive levels so no access opens out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         seq_q    <= '0;
         ce_n_q   <= 1'b1;
         ce2_q    <= 1'b0;
         ce3_n_q  <= 1'b1;
         adsp_n_q <= 1'b1;
         adsc_n_q <= 1'b1;
         adv_n_q  <= 1'b1;
         gw_n_q   <= 1'b1;
         bwe_n_q  <= 1'b1;
         bw_n_q   <= '1;
         wdata_q  <= '0;
         sleep_q  <= 1'b0;
      end else begin
         addr_q   <= addr_i;
         seq_q    <= seq_addr_i;
         ce_n_q   <= ce_n_i;
         ce2_q    <= ce2_i;
         ce3_n_q  <= ce3_n_i;
         adsp_n_q <= adsp_n_i;
         adsc_n_q <= adsc_n_i;
         adv_n_q  <= adv_n_i;
         gw_n_q   <= gw_n_i;
         bwe_n_q  <= bwe_n_i;
         bw_n_q   <= bw_n_i;
         wdata_q  <= wdata_i;
         sleep_q  <= sleep_i;
      end
   end

endmodule

// File: rtl/ssram_access.sv
module ssram_access
   import ssram_pkg::*;
#(
   parameter int AW      = 6,
   parameter int NB      = 4,
   parameter int REC_CYC = 2,
   localparam int RW     = $clog2(REC_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_q,
   input  logic [AW-1:0] seq_q,
   input  logic          ce_n_q,
   input  logic          ce2_q,
   input  logic          ce3_n_q,
   input  logic          adsp_n_q,
   input  logic          adsc_n_q,
   input  logic          adv_n_q,
   input  logic          gw_n_q,
   input  logic          bwe_n_q,
   input  logic [NB-1:0] bw_n_q,
   input  logic          sleep_q,
   output op_e           op_o,
   output logic          rd_start_o,
   output logic [AW-1:0] acc_addr_o,
   output logic [NB-1:0] lane_en_o
);

   logic          active_q, active_d;
   logic [AW-1:0] cur_q;
   logic [RW-1:0] rec_q;
   logic          chip_sel, p_go, c_go, strobe;
   logic          acc, start, desel, wr_req, blocked;

   always_comb begin
      chip_sel   = !ce_n_q && ce2_q && !ce3_n_q;
      p_go       = !adsp_n_q && !ce_n_q;
      c_go       = !adsc_n_q;
      strobe     = p_go || c_go;
      active_d   = active_q;
      acc        = 1'b0;
      start      = 1'b0;
      desel      = 1'b0;
      acc_addr_o = cur_q;
      if (sleep_q) begin
         active_d = 1'b0;
         desel    = 1'b1;
      end else if (strobe) begin
         if (chip_sel) begin
            active_d   = 1'b1;
            acc        = 1'b1;
            start      = 1'b1;
            acc_addr_o = addr_q;
         end else begin
            active_d = 1'b0;
            desel    = 1'b1;
         end
      end else if (active_q) begin
         acc = 1'b1;
         if (!adv_n_q) acc_addr_o = seq_q;
      end
   end

   // Global write covers every lane; otherwise the byte selects apply
   always_comb begin
      if (!gw_n_q)       lane_en_o = '1;
      else if (!bwe_n_q) lane_en_o = ~bw_n_q;
      else               lane_en_o = '0;
   end

   assign wr_req  = |lane_en_o;
   assign blocked = sleep_q || (rec_q != '0);

   always_comb begin
      if (desel)      op_o = OP_DESEL;
      else if (!acc)  op_o = OP_NONE;
      else if (!wr_req) op_o = OP_READ;
      else if (blocked) op_o = OP_NONE;
      else            op_o = OP_WRITE;
   end

   assign rd_start_o = start && (op_o == OP_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cur_q    <= '0;
         rec_q    <= '0;
      end else begin
         active_q <= active_d;
         if (acc) cur_q <= acc_addr_o;
         if (sleep_q)            rec_q <= RW'(REC_CYC);
         else if (rec_q != '0)   rec_q <= rec_q - RW'(1);
      end
   end

endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
   parameter int AW = 6,
   parameter int NB = 4,
   parameter int BW = 8,
   localparam int DW    = NB * BW,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [NB-1:0] lane_en_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o
);

   // One storage bank per byte lane; each bank has its own write enable
   for (genvar g = 0; g < NB; g++) begin : g_lane
      logic [BW-1:0] cells [DEPTH];
      logic [BW-1:0] rd_lane;

      always_ff @(posedge clk) begin
         if (we_i && lane_en_i[g]) cells[addr_i] <= wdata_i[g*BW +: BW];
         rd_lane <= cells[addr_i];
      end

      assign rdata_o[g*BW +: BW] = rd_lane;
   end

endmodule

// File: rtl/ssram_outpipe.sv
module ssram_outpipe
   import ssram_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  op_e           op_i,
   input  logic          rd_start_i,
   input  logic [DW-1:0] rdata_i,
   input  logic          oe_n_i,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe_o
);

   logic          v1_q, v2_q, hold_q;
   logic [DW-1:0] dout_q;
   logic          kill;

   assign kill = (op_i == OP_DESEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q   <= 1'b0;
         v2_q   <= 1'b0;
         hold_q <= 1'b0;
         dout_q <= '0;
      end else begin
         v1_q <= (op_i == OP_READ);
         v2_q <= v1_q && !kill;
         if (v1_q) dout_q <= rdata_i;
         if (op_i == OP_WRITE) hold_q <= 1'b1;
         else if (rd_start_i)  hold_q <= 1'b0;
      end
   end

   assign dq_oe_o = !oe_n_i && v2_q && !hold_q && (op_i != OP_WRITE);
   assign dq_o    = dq_oe_o ? dout_q : '0;

endmodule

// File: rtl/ssram_ctl_front.sv
module ssram_ctl_front
   import ssram_pkg::*;
#(
   parameter int AW      = 6,
   parameter int NB      = 4,
   parameter int BW      = 8,
   parameter int REC_CYC = 2,
   localparam int DW     = NB * BW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] seq_addr_i,
   input  logic          ce_n_i,
   input  logic          ce2_i,
   input  logic          ce3_n_i,
   input  logic          adsp_n_i,
   input  logic          adsc_n_i,
   input  logic          adv_n_i,
   input  logic          gw_n_i,
   input  logic          bwe_n_i,
   input  logic [NB-1:0] bw_n_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          oe_n_i,
   input  logic          sleep_i,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe_o
);

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("ssram_ctl_front: AW must lie in 1..12");
   end
   if (NB < 1 || BW < 1) begin : g_bad_lanes
      $error("ssram_ctl_front: NB and BW must be at least 1");
   end
   if (REC_CYC < 1) begin : g_bad_rec
      $error("ssram_ctl_front: REC_CYC must be at least 1");
   end

   logic [AW-1:0] addr_q, seq_q, acc_addr;
   logic          ce_n_q, ce2_q, ce3_n_q, adsp_n_q, adsc_n_q, adv_n_q;
   logic          gw_n_q, bwe_n_q, sleep_q, rd_start, arr_we;
   logic [NB-1:0] bw_n_q, lane_en;
   logic [DW-1:0] wdata_q, rdata;
   op_e           op;

   ssram_in_reg #(.AW(AW), .NB(NB), .BW(BW)) u_in (
      .clk, .rst_n,
      .addr_i, .seq_addr_i, .ce_n_i, .ce2_i, .ce3_n_i,
      .adsp_n_i, .adsc_n_i, .adv_n_i, .gw_n_i, .bwe_n_i,
      .bw_n_i, .wdata_i, .sleep_i,
      .addr_q, .seq_q, .ce_n_q, .ce2_q, .ce3_n_q,
      .adsp_n_q, .adsc_n_q, .adv_n_q, .gw_n_q, .bwe_n_q,
      .bw_n_q, .wdata_q, .sleep_q
   );

   ssram_access #(.AW(AW), .NB(NB), .REC_CYC(REC_CYC)) u_acc (
      .clk, .rst_n,
      .addr_q, .seq_q, .ce_n_q, .ce2_q, .ce3_n_q,
      .adsp_n_q, .adsc_n_q, .adv_n_q, .gw_n_q, .bwe_n_q,
      .bw_n_q, .sleep_q,
      .op_o(op), .rd_start_o(rd_start), .acc_addr_o(acc_addr), .lane_en_o(lane_en)
   );

   assign arr_we = (op == OP_WRITE);

   ssram_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
      .clk, .we_i(arr_we), .addr_i(acc_addr), .lane_en_i(lane_en),
      .wdata_i(wdata_q), .rdata_o(rdata)
   );

   ssram_outpipe #(.DW(DW)) u_out (
      .clk, .rst_n, .op_i(op), .rd_start_i(rd_start), .rdata_i(rdata),
      .oe_n_i, .dq_o, .dq_oe_o
   );

endmodule

// File: rtl/ssram_ctl_chk.sv
module ssram_ctl_chk
   import ssram_pkg::*;
#(
   parameter int NB = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          oe_n_i,
   input logic          dq_oe_o,
   input logic          sleep_q,
   input op_e           op,
   input logic          arr_we,
   input logic [NB-1:0] lane_en,
   input logic          gw_n_q,
   input logic          bwe_n_q,
   input logic [NB-1:0] bw_n_q
);

   // R5
   oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_i |-> !dq_oe_o);

   // R4
   wr_bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> !dq_oe_o);

   // R6
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |=> !dq_oe_o);

   // R9
   desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DESEL) |=> !dq_oe_o);

   // R10
   sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_q |=> !dq_oe_o);

   // R10
   sleep_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_q |-> !arr_we);

   // R11
   wake_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_q) |-> !arr_we);

   // R11
   wake_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_q) |=> !arr_we);

   // R2
   gw_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && !gw_n_q) |-> (lane_en == {NB{1'b1}}));

   // R3
   bw_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && gw_n_q) |-> (!bwe_n_q && (lane_en == ~bw_n_q)));

endmodule

bind ssram_ctl_front ssram_ctl_chk #(.NB(NB)) u_chk (
   .clk(clk), .rst_n(rst_n), .oe_n_i(oe_n_i), .dq_oe_o(dq_oe_o),
   .sleep_q(sleep_q), .op(op), .arr_we(arr_we), .lane_en(lane_en),
   .gw_n_q(gw_n_q), .bwe_n_q(bwe_n_q), .bw_n_q(bw_n_q)
);

// File: tb/test_ssram_ctl_front.sv
`timescale 1ns/1ps
module test_ssram_ctl_front;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr_i = '0, seq_addr_i = '0;
   logic        ce_n_i = 1'b0, ce2_i = 1'b1, ce3_n_i = 1'b0;
   logic        adsp_n_i = 1'b1, adsc_n_i = 1'b1, adv_n_i = 1'b1;
   logic        gw_n_i = 1'b1, bwe_n_i = 1'b1;
   logic [3:0]  bw_n_i = 4'hF;
   logic [31:0] wdata_i = '0;
   logic        oe_n_i = 1'b0, sleep_i = 1'b0;
   logic [31:0] dq_o;
   logic        dq_oe_o;

   ssram_ctl_front i_ssram_ctl_front (
      .clk, .rst_n, .addr_i, .seq_addr_i, .ce_n_i, .ce2_i, .ce3_n_i,
      .adsp_n_i, .adsc_n_i, .adv_n_i, .gw_n_i, .bwe_n_i, .bw_n_i,
      .wdata_i, .oe_n_i, .sleep_i, .dq_o, .dq_oe_o
   );

   always #10 clk = ~clk;

   int    n_chk = 0, n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R13";

   // Reference model state
   logic [31:0] mm [64];
   bit          m_act = 0, m_hold = 0, m_raw = 0;
   int          m_cur = 0, m_slp = 1000;
   int          h_op [3] = '{0, 0, 0};   // 0 none, 1 read, 2 write, 3 deselect
   bit          h_st [3] = '{0, 0, 0};
   logic [31:0] h_dat [3];
   logic [31:0] m_dat = '0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      int op; bit st; bit chip; logic [3:0] ln; logic [31:0] rd;
      op = 0; st = 0; rd = '0;
      for (int i = 2; i > 0; i--) begin
         h_op[i] = h_op[i-1]; h_st[i] = h_st[i-1]; h_dat[i] = h_dat[i-1];
      end
      chip = !ce_n_i && ce2_i && !ce3_n_i;
      if (sleep_i) begin
         m_act = 0; op = 3; m_slp = 0;
      end else begin
         if (m_slp < 1000) m_slp++;
         if ((!adsp_n_i && !ce_n_i) || !adsc_n_i) begin
            if (chip) begin m_act = 1; m_cur = int'(addr_i); st = 1; op = 1; end
            else begin m_act = 0; op = 3; end
         end else if (m_act) begin
            if (!adv_n_i) m_cur = int'(seq_addr_i);
            op = 1;
         end
         if (op == 1) begin
            ln = !gw_n_i ? 4'hF : (!bwe_n_i ? ~bw_n_i : 4'h0);
            if (ln != 4'h0) begin
               if (m_slp <= 2) op = 0;
               else begin
                  op = 2;
                  for (int b = 0; b < 4; b++)
                     if (ln[b]) mm[m_cur][8*b +: 8] = wdata_i[8*b +: 8];
               end
            end else rd = mm[m_cur];
         end
      end
      h_op[0] = op; h_st[0] = st; h_dat[0] = rd;
      if (h_op[1] == 2) m_hold = 1;
      else if (h_op[1] == 1 && h_st[1]) m_hold = 0;
      m_raw = (h_op[2] == 1) && (h_op[1] != 3) && !m_hold && (h_op[0] != 2);
      m_dat = h_dat[2];
   endtask

   // One clock: model follows the edge, outputs compared mid-cycle
   task automatic cyc();
      logic en;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      en = m_raw && !oe_n_i;
      chk(cur_req, {31'b0, dq_oe_o}, {31'b0, en});
      chk(cur_req, dq_o, en ? m_dat : 32'h0);
   endtask

   task automatic s(input logic p_n, input logic c_n, input logic v_n,
                    input logic [5:0] a, input logic [5:0] sq,
                    input logic g_n, input logic be_n, input logic [3:0] b_n,
                    input logic [31:0] d);
      adsp_n_i = p_n; adsc_n_i = c_n; adv_n_i = v_n;
      addr_i = a; seq_addr_i = sq; gw_n_i = g_n; bwe_n_i = be_n;
      bw_n_i = b_n; wdata_i = d;
      cyc();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) s(1, 1, 1, 0, 0, 1, 1, 4'hF, 0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) mm[i] = '0;
      for (int i = 0; i < 3; i++) h_dat[i] = '0;
      repeat (3) @(negedge clk);
      // R13: bus undriven in reset
      chk("R13", {31'b0, dq_oe_o}, 32'h0);
      rst_n = 1'b1;
      cur_req = "R13"; idle(3);

      // R2: global write fills all lanes even with byte selects inactive
      cur_req = "R2";
      s(1, 0, 1, 6'd4,  0, 0, 1, 4'hF, 32'h1122_3344);
      s(1, 0, 1, 6'd8,  0, 0, 0, 4'h0, 32'h8888_0008);
      s(1, 0, 1, 6'd9,  0, 0, 1, 4'hF, 32'h9999_0009);
      s(1, 0, 1, 6'd10, 0, 0, 1, 4'hF, 32'hAAAA_000A);
      s(1, 0, 1, 6'd11, 0, 0, 1, 4'hF, 32'hBBBB_000B);
      s(1, 0, 1, 6'd20, 0, 0, 1, 4'hF, 32'h5A5A_5A5A);
      s(1, 0, 1, 6'd5,  0, 0, 1, 4'hF, 32'h0);

      // R3: lane 0 only, then lanes 2 and 3, then a disabled byte write reads
      cur_req = "R3";
      s(1, 0, 1, 6'd4, 0, 1, 0, 4'b1110, 32'hAAAA_AAAA);
      s(1, 0, 1, 6'd5, 0, 1, 0, 4'b0011, 32'hFFFF_FFFF);
      s(1, 0, 1, 6'd4, 0, 1, 1, 4'b0000, 32'h7777_7777);
      idle(2);
      s(1, 0, 1, 6'd5, 0, 1, 1, 4'hF, 0);
      idle(2);

      // R7: strobe read then advance through sequencer addresses
      cur_req = "R7";
      s(0, 1, 1, 6'd8, 0, 1, 1, 4'hF, 0);
      s(1, 1, 0, 0, 6'd9,  1, 1, 4'hF, 0);
      s(1, 1, 0, 0, 6'd10, 1, 1, 4'hF, 0);
      s(1, 1, 0, 0, 6'd11, 1, 1, 4'hF, 0);
      // R12: suspend repeats the last address
      cur_req = "R12";
      idle(3);

      // R4: a write in the middle of a read burst turns the bus off
      cur_req = "R4";
      s(0, 1, 1, 6'd8, 0, 1, 1, 4'hF, 0);
      s(1, 1, 0, 0, 6'd9,  1, 1, 4'hF, 0);
      s(1, 1, 0, 0, 6'd10, 0, 1, 4'hF, 32'hCAFE_000A);
      // R6: continued reads stay undriven until a strobe read
      cur_req = "R6";
      s(1, 1, 0, 0, 6'd4, 1, 1, 4'hF, 0);
      s(1, 1, 0, 0, 6'd10, 1, 1, 4'hF, 0);
      idle(2);
      s(0, 1, 1, 6'd10, 0, 1, 1, 4'hF, 0);
      idle(3);

      // R8: processor strobe with primary select off is ignored
      cur_req = "R8";
      s(0, 1, 1, 6'd8, 0, 1, 1, 4'hF, 0);
      ce_n_i = 1'b1;
      s(0, 1, 0, 6'd4, 6'd9, 1, 1, 4'hF, 0);
      ce_n_i = 1'b0;
      s(1, 1, 0, 0, 6'd11, 1, 1, 4'hF, 0);
      idle(2);
      // R8 and R9: controller strobe while unselected closes the access
      cur_req = "R9";
      ce2_i = 1'b0;
      s(1, 0, 1, 6'd4, 0, 1, 1, 4'hF, 0);
      ce2_i = 1'b1;
      idle(3);
      s(0, 1, 1, 6'd9, 0, 1, 1, 4'hF, 0);
      ce3_n_i = 1'b1;
      s(1, 0, 1, 6'd4, 0, 1, 1, 4'hF, 0);
      ce3_n_i = 1'b0;
      idle(2);

      // R5: asynchronous output enable
      cur_req = "R5";
      s(0, 1, 1, 6'd4, 0, 1, 1, 4'hF, 0);
      idle(2);
      oe_n_i = 1'b1; #1;
      chk("R5", {31'b0, dq_oe_o}, 32'h0);
      chk("R5", dq_o, 32'h0);
      oe_n_i = 1'b0; #1;
      chk("R5", {31'b0, dq_oe_o}, {31'b0, m_raw});
      oe_n_i = 1'b1;
      idle(1);
      oe_n_i = 1'b0;
      idle(1);

      // R1: strobe pulse between edges does nothing
      cur_req = "R1";
      s(1, 0, 1, 6'd8, 0, 1, 1, 4'hF, 0);
      #2 adsc_n_i = 1'b0; addr_i = 6'd20; gw_n_i = 1'b0;
      #3 adsc_n_i = 1'b1; gw_n_i = 1'b1;
      cyc();
      idle(2);

      // R10: sleep closes the access; strobes during sleep do nothing
      cur_req = "R10";
      sleep_i = 1'b1;
      s(0, 1, 1, 6'd4, 0, 1, 1, 4'hF, 0);
      s(1, 0, 1, 6'd20, 0, 0, 1, 4'hF, 32'h1111_1111);
      idle(1);
      sleep_i = 1'b0;
      // R11: writes in both recovery cycles are dropped
      cur_req = "R11";
      s(1, 0, 1, 6'd20, 0, 0, 1, 4'hF, 32'hDEAD_BEEF);
      s(1, 0, 1, 6'd20, 0, 1, 0, 4'h0, 32'hDEAD_BEEF);
      s(0, 1, 1, 6'd20, 0, 1, 1, 4'hF, 0);
      idle(2);
      s(1, 0, 1, 6'd20, 0, 0, 1, 4'hF, 32'h0BAD_F00D);
      s(0, 1, 1, 6'd20, 0, 1, 1, 4'hF, 0);
      idle(3);

      done = 1'b1;
      finish_run();
   end

endmodule